// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is a single-master I2C controller driven one command at a time by a host. The host asks it to open a transaction with a start condition, to open a new one with a repeated start while the bus is still held, to send a byte, to receive a byte and answer it with ACK or NACK, or to close the transaction with a stop condition. The block produces the clock and data waveforms on two open-drain lines, returns each received byte and the acknowledge given by the slave, and pulses a completion flag when each command finishes.

Both line inputs pass through digital deglitch filters before anything is sampled or any bus condition is detected. A bus monitor watches the filtered lines, keeps a bus-busy flag, and after each stop counts out a mode-dependent bus-free time before it lets a new start go out. Standard and fast modes are chosen by an input. All timing comes from the system clock through parameterized divider counts.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are low (both lines released), `cmd_ready` is high, `done` is low and `bus_busy` is low.
- R2: A start command (op 0) is legal only when no transaction is held. It holds off until the bus is free, then pulls data low while clock is released, and one half period later pulls clock low; `done` then pulses and the bus is held with both lines pulled low.
- R3: `bus_busy` rises after a start condition (data falling while clock high) and falls after a stop condition (data rising while clock high), both seen on the filtered lines.
- R4: A write command (op 2) sends `cmd_data` as 8 bits, most significant first, one bit per clock pulse, followed by a ninth pulse during which data is released. Data changes only at the midpoint of the clock low phase and stays stable while clock is released.
- R5: For a write, `nack` is 1 if the data line is high at the middle of the ninth clock high phase and 0 if a slave holds it low. Every command ends with a `done` pulse of exactly one cycle.
- R6: A repeated start command (op 1) releases data while clock is low, releases clock, then pulls data low while clock is high; `bus_busy` stays high throughout.
- R7: A read command (op 3) releases data for 8 clock pulses and shifts in the bit sampled in the middle of each high phase, most significant first, into `rx_data`. On the ninth pulse it pulls data low when `cmd_ack` is 1 and releases it when `cmd_ack` is 0.
- R8: A stop command (op 4) pulls data low while clock is low, releases clock, then releases data while clock is high, leaving both lines released and the controller idle.
- R9: After a stop is detected, no new start begins before the bus-free count (STD_FREE = 588 cycles in standard mode, FAST_FREE = 163 cycles in fast mode with the defaults, 4.7 µs and 1.3 µs at 125 MHz) has elapsed.
- R10: A pulse on either line input that lasts fewer than FILT_CYC (default 13) system clocks is discarded and causes no bus condition.
- R11: Each clock period is four quarters, two low and two high. A quarter lasts STD_QTR = 312 cycles when `fast_mode` is 0 and FAST_QTR = 78 when it is 1, with `fast_mode` sampled when the command is accepted.
- R12: An illegal command (anything but start while idle; start while held; op codes 5 to 7) completes with a `done` pulse and leaves both lines unchanged.
- R13: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while idle or while holding the bus between commands, and is high on every cycle that carries `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1 selects fast mode, 0 standard mode |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 3 | Command code: 0 start, 1 repeated start, 2 write, 3 read, 4 stop |
| cmd_data | input | 8 | Byte to send for a write |
| cmd_ack | input | 1 | For a read: 1 answers with ACK, 0 with NACK |
| done | output | 1 | One-cycle pulse when a command completes |
| nack | output | 1 | Slave acknowledge result of the last write (1 = not acknowledged) |
| rx_data | output | 8 | Byte received by the last read |
| bus_busy | output | 1 | Bus is between a start and a stop |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
On every cycle the assertions check that data never moves while clock is released during a byte, that the only data edges while clock is high are the falling edge of a start or repeated start and the rising edge of a stop, that the busy flag follows detected start and stop conditions, that the filter output holds while its input agrees with it, that a start waiting for a free bus leaves the lines alone, and that `done` is a single cycle that returns the controller to a ready state. The byte values sent and received, the slave and master acknowledge outcomes, the exact clock high width in each mode, the length of the bus-free gap, the rejection of short glitches and the handling of illegal commands can only be shown by the bench's scenarios, which use a behavioural slave on the wired-AND lines.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HELD,
        ST_WAIT_FREE,
        ST_LAUNCH,
        ST_RUN
    } state_e;

    // Line behaviour for one quarter of a clock period
    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic sda_keep;
        logic sample;
    } drive_s;

    localparam int unsigned BYTE_BITS = 8;
    localparam logic [5:0]  BYTE_LAST_Q = 6'd36;

    function automatic logic [5:0] last_quarter(op_e op);
        case (op)
            OP_START:   return 6'd3;
            OP_RESTART: return 6'd5;
            OP_STOP:    return 6'd4;
            default:    return BYTE_LAST_Q;
        endcase
    endfunction

    function automatic logic cmd_legal(logic [2:0] op, logic held);
        if (held)
            return (op == OP_RESTART) || (op == OP_WRITE) ||
                   (op == OP_READ) || (op == OP_STOP);
        return op == OP_START;
    endfunction

    function automatic drive_s drive_at(op_e op, logic [5:0] q,
                                        logic [7:0] data, logic ack_en);
        drive_s     d;
        logic [3:0] b;
        d = '{scl_low: 1'b0, sda_low: 1'b0, sda_keep: 1'b0, sample: 1'b0};
        b = q[5:2];
        case (op)
            OP_START: begin
                d.scl_low = (q == 6'd3);
                d.sda_low = (q != 6'd0);
            end
            OP_RESTART: begin
                d.scl_low  = (q < 6'd2) || (q == 6'd5);
                d.sda_low  = (q >= 6'd4);
                d.sda_keep = (q == 6'd0);
            end
            OP_STOP: begin
                d.scl_low  = (q < 6'd2);
                d.sda_low  = (q >= 6'd1) && (q <= 6'd3);
                d.sda_keep = (q == 6'd0);
            end
            OP_WRITE, OP_READ: begin
                if (q == BYTE_LAST_Q) begin
                    d.scl_low  = 1'b1;
                    d.sda_keep = 1'b1;
                end else begin
                    d.scl_low  = (q[1:0] < 2'd2);
                    d.sda_keep = (q[1:0] != 2'd1);
                    d.sample   = (q[1:0] == 2'd3);
                    if (b < 4'd8)
                        d.sda_low = (op == OP_WRITE) ? ~data[3'd7 - b[2:0]] : 1'b0;
                    else
                        d.sda_low = (op == OP_READ) ? ack_en : 1'b0;
                end
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cm_filter.sv
module i2cm_filter #(
    parameter int FILT_CYC = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            dout <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
                dout <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: output only moves after the synchronised input has disagreed with it
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (s2 == dout) |=> $stable(dout));

endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
    parameter int STD_FREE  = 588,
    parameter int FAST_FREE = 163
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_mode,
    input  logic scl_f,
    input  logic sda_f,
    output logic busy,
    output logic bus_free
);
    localparam int MAXF = (STD_FREE > FAST_FREE) ? STD_FREE : FAST_FREE;
    localparam int FW   = $clog2(MAXF + 1);

    logic          scl_p, sda_p;
    logic [FW-1:0] free_cnt;
    logic          start_det, stop_det;

    assign start_det = scl_p && scl_f && sda_p && !sda_f;
    assign stop_det  = scl_p && scl_f && !sda_p && sda_f;
    assign bus_free  = !busy && (free_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            busy     <= 1'b0;
            free_cnt <= '0;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
            if (start_det)
                busy <= 1'b1;
            else if (stop_det)
                busy <= 1'b0;
            if (stop_det)
                free_cnt <= fast_mode ? FW'(FAST_FREE) : FW'(STD_FREE);
            else if (free_cnt != '0)
                free_cnt <= free_cnt - 1'b1;
        end
    end

    p_busy_start_r3: assert property (@(posedge clk) disable iff (rst)
        start_det |=> busy);

    p_busy_stop_r3: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!busy && !bus_free));

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int STD_QTR  = 312,
    parameter int FAST_QTR = 78
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast_mode,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    input  logic       bus_free,
    input  logic       sda_f,
    output logic       done,
    output logic       nack,
    output logic [7:0] rx_data,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int MAXQ = (STD_QTR > FAST_QTR) ? STD_QTR : FAST_QTR;
    localparam int QW   = $clog2(MAXQ + 1);

    state_e        state;
    op_e           op_q;
    logic [7:0]    data_q;
    logic          ack_q;
    logic [QW-1:0] qtr_q, qcnt;
    logic [5:0]    qidx, q_sel;
    drive_s        d;
    logic          at_last, apply_en;

    assign cmd_ready = (state == ST_IDLE) || (state == ST_HELD);
    assign at_last   = (qidx == last_quarter(op_q));
    assign q_sel     = (state == ST_RUN) ? qidx + 6'd1 : 6'd0;
    assign d         = drive_at(op_q, q_sel, data_q, ack_q);
    assign apply_en  = (state == ST_LAUNCH) ||
                       ((state == ST_RUN) && (qcnt == '0) && !at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_START;
            data_q  <= '0;
            ack_q   <= 1'b0;
            qtr_q   <= '0;
            qcnt    <= '0;
            qidx    <= '0;
            done    <= 1'b0;
            nack    <= 1'b0;
            rx_data <= '0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE, ST_HELD: begin
                    if (cmd_valid) begin
                        op_q   <= op_e'(cmd_op);
                        data_q <= cmd_data;
                        ack_q  <= cmd_ack;
                        qtr_q  <= fast_mode ? QW'(FAST_QTR) : QW'(STD_QTR);
                        if (cmd_legal(cmd_op, state == ST_HELD))
                            state <= (state == ST_IDLE) ? ST_WAIT_FREE : ST_LAUNCH;
                        else
                            done <= 1'b1;
                    end
                end
                ST_WAIT_FREE: begin
                    if (bus_free)
                        state <= ST_LAUNCH;
                end
                ST_LAUNCH: begin
                    state <= ST_RUN;
                    qidx  <= '0;
                    qcnt  <= qtr_q - 1'b1;
                end
                ST_RUN: begin
                    if (qcnt != '0) begin
                        qcnt <= qcnt - 1'b1;
                    end else if (at_last) begin
                        done  <= 1'b1;
                        state <= (op_q == OP_STOP) ? ST_IDLE : ST_HELD;
                    end else begin
                        qidx <= qidx + 6'd1;
                        qcnt <= qtr_q - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase

            if (apply_en) begin
                scl_oe <= d.scl_low;
                if (!d.sda_keep)
                    sda_oe <= d.sda_low;
                if (d.sample) begin
                    if (q_sel[5:2] < 4'(BYTE_BITS))
                        rx_data <= {rx_data[6:0], sda_f};
                    else
                        nack <= sda_f;
                end
            end
        end
    end

    // R4: data stays put while the clock line is released inside a byte
    p_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && ((op_q == OP_WRITE) || (op_q == OP_READ)) &&
         !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

    // R2, R6: data may fall with clock high only for a start or repeated start
    p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |->
        ((op_q == OP_START) || (op_q == OP_RESTART)));

    // R8: data may rise with clock high only for a stop
    p_stop_edge_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (op_q == OP_STOP));

    // R9: a start waiting for the bus leaves both lines alone
    p_wait_free_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_FREE) && !bus_free) |=>
        ($stable(scl_oe) && $stable(sda_oe) && (state == ST_WAIT_FREE)));

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13: a completed command leaves the controller ready
    p_done_ready_r13: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
    parameter int STD_QTR   = 312,
    parameter int FAST_QTR  = 78,
    parameter int STD_FREE  = 588,
    parameter int FAST_FREE = 163,
    parameter int FILT_CYC  = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast_mode,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    output logic       done,
    output logic       nack,
    output logic [7:0] rx_data,
    output logic       bus_busy,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int NLINES = 2;
    localparam int SDA_IX = 0;
    localparam int SCL_IX = 1;

    logic [NLINES-1:0] raw, filt;
    logic              bus_free;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2cm_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    i2cm_bus_mon #(
        .STD_FREE  (STD_FREE),
        .FAST_FREE (FAST_FREE)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .fast_mode (fast_mode),
        .scl_f     (filt[SCL_IX]),
        .sda_f     (filt[SDA_IX]),
        .busy      (bus_busy),
        .bus_free  (bus_free)
    );

    i2cm_engine #(
        .STD_QTR  (STD_QTR),
        .FAST_QTR (FAST_QTR)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .fast_mode (fast_mode),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_ack   (cmd_ack),
        .bus_free  (bus_free),
        .sda_f     (filt[SDA_IX]),
        .done      (done),
        .nack      (nack),
        .rx_data   (rx_data),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;

    localparam int FAST_QTR  = 78;
    localparam int STD_QTR   = 312;
    localparam int FAST_FREE = 163;
    localparam int STD_FREE  = 588;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_mode = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ack = 1'b0;
    logic       cmd_ready, done, nack, bus_busy, scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic       scl_i, sda_i;

    // wired-AND lines
    logic glitch = 1'b0;
    logic slv_pull;
    wire  scl_line = ~scl_oe;
    wire  sda_line = ~(sda_oe | slv_pull | glitch);
    assign scl_i = scl_line;
    assign sda_i = sda_line;

    always #4 clk = ~clk;

    i2c_byte_master u_dut (
        .clk(clk), .rst(rst), .fast_mode(fast_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ack(cmd_ack), .done(done), .nack(nack),
        .rx_data(rx_data), .bus_busy(bus_busy), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural slave ----------------
    int         slv_pos = -1;
    logic       slv_quiet = 1'b1;
    logic       slv_tx = 1'b0;
    logic [7:0] slv_tx_byte = '0;
    logic       slv_ack = 1'b1;
    logic [7:0] slv_rx = '0;
    logic       slv_mack = 1'b0;

    always @* begin
        if (slv_quiet || slv_pos < 0)
            slv_pull = 1'b0;
        else if (slv_tx)
            slv_pull = (slv_pos < 8) ? !slv_tx_byte[3'(7 - slv_pos)] : 1'b0;
        else
            slv_pull = (slv_pos == 8) && slv_ack;
    end

    always @(negedge sda_line) if (scl_line) begin
        slv_pos   = -1;
        slv_quiet = 1'b0;
    end

    always @(posedge sda_line) if (scl_line) slv_quiet = 1'b1;

    always @(negedge scl_line) slv_pos = (slv_pos >= 8) ? 0 : slv_pos + 1;

    always @(posedge scl_line) begin
        if (slv_pos >= 0 && slv_pos < 8)
            slv_rx = {slv_rx[6:0], sda_line};
        else if (slv_pos == 8) begin
            slv_mack = ~sda_line;
            if (slv_tx && sda_line) slv_quiet = 1'b1;
        end
    end

    // ---------------- line monitors ----------------
    int   hi_cnt = 0, last_hi = 0;
    int   gap_cnt = 0, last_gap = 0;
    bit   gap_run = 0;
    logic prev_sda = 1'b0, prev_busy = 1'b0;
    bit   busy_drop = 0, busy_ever = 0;

    always @(negedge clk) begin
        if (!scl_oe) hi_cnt++;
        else begin
            if (hi_cnt > 0) last_hi = hi_cnt;
            hi_cnt = 0;
        end
        if (prev_sda && !sda_oe && !scl_oe) begin
            gap_run = 1; gap_cnt = 0;
        end else if (gap_run) gap_cnt++;
        if (!prev_sda && sda_oe && !scl_oe && gap_run) begin
            last_gap = gap_cnt; gap_run = 0;
        end
        if (prev_busy && !bus_busy) busy_drop = 1;
        if (bus_busy) busy_ever = 1;
        prev_sda  = sda_oe;
        prev_busy = bus_busy;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        string      req;
        int         kind;   // 0 done only, 1 nack, 2 rx byte
        logic [7:0] val;
    } exp_t;
    exp_t sb[$];

    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) chk(0, "R5 unexpected done", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                case (e.kind)
                    1: chk(nack == e.val[0], e.req, nack, e.val[0]);
                    2: chk(rx_data == e.val, e.req, rx_data, e.val);
                    default: chk(1'b1, e.req, 1, 1);
                endcase
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [7:0] data, input logic ack,
                         input int kind, input logic [7:0] val, input string req);
        sb.push_back('{req, kind, val});
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_data = data; cmd_ack = ack; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(cmd_ready && !done && !bus_busy, "R1 ready idle", {cmd_ready, done, bus_busy}, 3'b100);

        // R12 illegal commands while idle
        issue(3'd2, 8'hFF, 1'b0, 0, 0, "R12 write in idle");
        chk(!scl_oe && !sda_oe && !bus_busy, "R12 idle write no bus change", {scl_oe, sda_oe, bus_busy}, 0);
        issue(3'd7, 8'h00, 1'b0, 0, 0, "R12 bad opcode");
        chk(!scl_oe && !sda_oe, "R12 bad opcode no bus change", {scl_oe, sda_oe}, 0);

        // R10 short glitch rejected
        busy_ever = 0;
        glitch = 1'b1; repeat (10) @(negedge clk); glitch = 1'b0;
        repeat (40) @(negedge clk);
        chk(!busy_ever, "R10 short pulse ignored", busy_ever, 0);
        // long pulse seen as start then stop
        glitch = 1'b1; repeat (24) @(negedge clk);
        chk(bus_busy, "R3 long pulse gives start", bus_busy, 1);
        glitch = 1'b0; repeat (30) @(negedge clk);
        chk(!bus_busy, "R3 release gives stop", bus_busy, 0);

        // R2 start in fast mode
        slv_tx = 1'b0; slv_ack = 1'b1;
        issue(3'd0, 8'h00, 1'b0, 0, 0, "R2 start done");
        chk(scl_oe && sda_oe, "R2 both lines held low", {scl_oe, sda_oe}, 2'b11);
        chk(bus_busy, "R3 busy after start", bus_busy, 1);

        // R12 start while held
        issue(3'd0, 8'h00, 1'b0, 0, 0, "R12 start in held");
        chk(scl_oe && sda_oe && bus_busy, "R12 held start no change", {scl_oe, sda_oe, bus_busy}, 3'b111);

        // R4 R5 write with slave ACK
        issue(3'd2, 8'hA5, 1'b0, 1, 8'h00, "R5 write acked nack=0");
        chk(slv_rx == 8'hA5, "R4 slave got byte MSB first", slv_rx, 8'hA5);
        chk(last_hi == 2 * FAST_QTR, "R11 fast clock high width", last_hi, 2 * FAST_QTR);

        // R5 write with slave NACK
        slv_ack = 1'b0;
        issue(3'd2, 8'h3C, 1'b0, 1, 8'h01, "R5 write not acked nack=1");
        chk(slv_rx == 8'h3C, "R4 second byte", slv_rx, 8'h3C);

        // R6 repeated start keeps bus busy
        slv_ack = 1'b1;
        busy_drop = 0;
        issue(3'd1, 8'h00, 1'b0, 0, 0, "R6 restart done");
        chk(!busy_drop && bus_busy, "R6 busy kept across restart", busy_drop, 0);
        chk(scl_oe && sda_oe, "R6 lines held after restart", {scl_oe, sda_oe}, 2'b11);

        // R7 reads
        slv_tx = 1'b1; slv_tx_byte = 8'h96;
        issue(3'd3, 8'h00, 1'b1, 2, 8'h96, "R7 read byte with ACK");
        chk(slv_mack == 1'b1, "R7 master ACK seen", slv_mack, 1);
        slv_tx_byte = 8'h5A;
        issue(3'd3, 8'h00, 1'b0, 2, 8'h5A, "R7 read byte with NACK");
        chk(slv_mack == 1'b0, "R7 master NACK seen", slv_mack, 0);
        slv_tx = 1'b0;

        // R8 stop
        issue(3'd4, 8'h00, 1'b0, 0, 0, "R8 stop done");
        chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
        repeat (2) @(negedge clk);
        chk(!bus_busy, "R3 R8 bus idle after stop", bus_busy, 0);

        // R9 fast bus-free gap
        issue(3'd0, 8'h00, 1'b0, 0, 0, "R9 start after stop fast");
        chk(last_gap >= FAST_FREE + FAST_QTR && last_gap <= FAST_FREE + FAST_QTR + 40,
            "R9 fast bus-free gap", last_gap, FAST_FREE + FAST_QTR);
        issue(3'd4, 8'h00, 1'b0, 0, 0, "R8 stop fast");

        // standard mode
        fast_mode = 1'b0;
        issue(3'd0, 8'h00, 1'b0, 0, 0, "R2 start std");
        chk(last_gap >= FAST_FREE + STD_QTR, "R9 gap with std start", last_gap, FAST_FREE + STD_QTR);
        issue(3'd2, 8'h81, 1'b0, 1, 8'h00, "R5 std write acked");
        chk(slv_rx == 8'h81, "R4 std byte", slv_rx, 8'h81);
        chk(last_hi == 2 * STD_QTR, "R11 std clock high width", last_hi, 2 * STD_QTR);
        issue(3'd4, 8'h00, 1'b0, 0, 0, "R8 stop std");
        issue(3'd0, 8'h00, 1'b0, 0, 0, "R9 start after stop std");
        chk(last_gap >= STD_FREE + STD_QTR && last_gap <= STD_FREE + STD_QTR + 40,
            "R9 std bus-free gap", last_gap, STD_FREE + STD_QTR);
        issue(3'd4, 8'h00, 1'b0, 0, 0, "R8 final stop");
        chk(cmd_ready && !bus_busy, "R13 ready after final stop", {cmd_ready, bus_busy}, 2'b10);
        chk(sb.size() == 0, "R5 every command completed", sb.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule